// File: doc/BRIEF.md
# Backplane Interrupt Handler and Priority Encoder

This block sits between a CPU and a backplane. It collects seven active-low backplane interrupt request lines and four local sources. It masks each backplane level with its own enable bit and gives the CPU a 3-bit code for the highest pending level. Local sources are not masked. The abort switch, power-fail and bus-clear requests all raise level 7. The on-board serial controller request raises level 3. Every request input passes through a two-flop synchroniser before it is masked and encoded.

The CPU acknowledges a level with a one-cycle request that carries the level number. The block then serves it in one of four ways:
- **Level 7:** the block signals an autovector and runs no bus cycle.
- **Level 3 with the serial source pending:** the block returns a locally configured vector and runs no bus cycle.
- **Other levels 1 to 6:** the block runs a backplane acknowledge cycle. It drives the level on address lines A3..A1 and pulls IACK low. It waits for the synchronised data-acknowledge, then captures the 8-bit ID vector from the low data byte. If data-acknowledge does not arrive within a parameterised number of cycles, the block reports a bus error instead.
- **Level 0:** the block reports a bus error.

Top module: `bus_irq_handler`

## Requirements
- R1: After synchronous reset, `cpu_ipl` is 000, `bus_iack_n` is 1, `bus_addr` is 000, and `cpu_vec_valid`, `cpu_autovec` and `cpu_berr` are 0.
- R2: Bit i of `bus_irq_n` and of `lvl_en` belongs to level i+1. A line pulled low at a level whose enable bit is 0 has no effect on `cpu_ipl`. A line is counted as pending only when it is low and its enable bit is 1.
- R3: `cpu_ipl` is the number of the highest pending level, or 000 when nothing is pending. A change on a request line shows on `cpu_ipl` after the second rising edge that follows it. A change of `lvl_en` shows in the same cycle.
- R4: `loc_abort`, `loc_acfail` and `loc_busclr` (active high) make level 7 pending. `loc_serial` makes level 3 pending. None of them depends on `lvl_en`.
- R5: An acknowledge of level 1 to 6 that is not level 3 with the serial source pending starts a bus cycle. After the edge that samples `ack_req`, `bus_iack_n` is 0 and `bus_addr` holds the level. Both stay unchanged until the cycle ends.
- R6: During a bus cycle, `bus_dtack_n` going low ends the cycle on the third rising edge after it goes low. On that edge `bus_data` is latched into `cpu_vec`, `cpu_vec_valid` is 1 for exactly one cycle, and `bus_iack_n` returns to 1.
- R7: An acknowledge of level 7 drives `cpu_autovec` high for one cycle after the sampling edge and runs no bus cycle.
- R8: An acknowledge of level 3 while the serial source is pending returns `serial_vec` on `cpu_vec`, with `cpu_vec_valid` high for one cycle after the sampling edge, and runs no bus cycle.
- R9: If `bus_dtack_n` does not go low within TMO_CYC cycles of the bus cycle, the block does three things on the TMO_CYC-th edge after the sampling edge. It releases `bus_iack_n`, it pulses `cpu_berr` for one cycle, and it leaves `cpu_vec_valid` at 0.
- R10: An acknowledge of level 0 pulses `cpu_berr` for one cycle after the sampling edge and runs no bus cycle.
- R11: After a vectored bus cycle, the block waits until the synchronised `bus_dtack_n` is high again. An `ack_req` that arrives in that time is dropped and starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_irq_n | input | 7 | Backplane interrupt requests, active low, bit i is level i+1 |
| lvl_en | input | 7 | Per-level enable for backplane requests |
| loc_abort | input | 1 | Abort switch request (level 7) |
| loc_acfail | input | 1 | Power-fail request (level 7) |
| loc_busclr | input | 1 | Bus-clear request (level 7) |
| loc_serial | input | 1 | Serial controller request (level 3) |
| serial_vec | input | 8 | Vector returned for the serial source |
| ack_req | input | 1 | One-cycle acknowledge request from the CPU |
| ack_lvl | input | 3 | Level being acknowledged |
| bus_dtack_n | input | 1 | Backplane data-acknowledge, active low |
| bus_data | input | 8 | Low data byte carrying the responder's ID vector |
| cpu_ipl | output | 3 | Highest pending level, 000 for none |
| bus_iack_n | output | 1 | Backplane interrupt acknowledge, active low |
| bus_addr | output | 3 | Level driven on A3..A1 during acknowledge |
| cpu_vec | output | 8 | Vector returned to the CPU |
| cpu_vec_valid | output | 1 | One-cycle strobe, `cpu_vec` is valid |
| cpu_autovec | output | 1 | One-cycle strobe, use the autovector |
| cpu_berr | output | 1 | One-cycle strobe, bus error |

## Verification
A stuck or skipped synchroniser stage moves the `cpu_ipl` change one cycle early or late. Checking that change at the exact cycle exposes it within two edges of the request. A wrong acknowledge state shows at the ports in one of three ways:
- The wrong level appears on `bus_addr`.
- `bus_iack_n` is low when an autovector or local vector was expected.
- A strobe comes a cycle off.

A broken timeout or release wait shows as a bus error at the wrong edge count, or as a second IACK assertion while data-acknowledge is still held low.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    localparam int NUM_LVL = 7;
    localparam int LVL_W   = 3;
    localparam int VEC_W   = 8;

    localparam logic [LVL_W-1:0] LVL_AUTO   = 3'd7;
    localparam logic [LVL_W-1:0] LVL_SERIAL = 3'd3;
    localparam logic [LVL_W-1:0] LVL_NONE   = 3'd0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_REL  = 2'd2
    } ack_state_t;

    typedef struct packed {
        logic             valid;
        logic             autovec;
        logic             berr;
        logic [VEC_W-1:0] vec;
    } cpu_resp_t;

    typedef struct packed {
        logic             iack_n;
        logic [LVL_W-1:0] addr;
    } bus_drv_t;

    // Highest set bit index + 1, or 0 when no bit is set.
    function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] pend);
        logic [LVL_W-1:0] r;
        r = LVL_NONE;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (pend[i]) r = LVL_W'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqh_sync.sv
module irqh_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irqh_prio.sv
module irqh_prio
    import irqh_pkg::*;
(
    input  logic [NUM_LVL-1:0] irq_n_s,
    input  logic [NUM_LVL-1:0] lvl_en,
    input  logic [2:0]         loc_top_s,
    input  logic               serial_s,
    output logic [LVL_W-1:0]   ipl,
    output logic               serial_pend
);
    logic [NUM_LVL-1:0] pend;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic local_hit;
        if (g == int'(LVL_AUTO) - 1) begin : g_auto
            assign local_hit = |loc_top_s;
        end else if (g == int'(LVL_SERIAL) - 1) begin : g_ser
            assign local_hit = serial_s;
        end else begin : g_none
            assign local_hit = 1'b0;
        end
        assign pend[g] = (~irq_n_s[g] & lvl_en[g]) | local_hit;
    end

    assign ipl         = top_level(pend);
    assign serial_pend = serial_s;
endmodule

// File: rtl/irqh_ack_fsm.sv
module irqh_ack_fsm
    import irqh_pkg::*;
#(
    parameter int TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_req,
    input  logic [LVL_W-1:0] ack_lvl,
    input  logic             serial_pend,
    input  logic [VEC_W-1:0] serial_vec,
    input  logic             dtack_n_s,
    input  logic [VEC_W-1:0] bus_data,
    output bus_drv_t         bus_drv,
    output cpu_resp_t        resp
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    ack_state_t       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            cnt            <= '0;
            bus_drv.iack_n <= 1'b1;
            bus_drv.addr   <= LVL_NONE;
            resp           <= '0;
        end else begin
            resp.valid   <= 1'b0;
            resp.autovec <= 1'b0;
            resp.berr    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ack_req) begin
                        if (ack_lvl == LVL_NONE) begin
                            resp.berr <= 1'b1;
                        end else if (ack_lvl == LVL_AUTO) begin
                            resp.autovec <= 1'b1;
                        end else if (ack_lvl == LVL_SERIAL && serial_pend) begin
                            resp.vec   <= serial_vec;
                            resp.valid <= 1'b1;
                        end else begin
                            state          <= ST_BUS;
                            cnt            <= '0;
                            bus_drv.iack_n <= 1'b0;
                            bus_drv.addr   <= ack_lvl;
                        end
                    end
                end
                ST_BUS: begin
                    if (!dtack_n_s) begin
                        resp.vec       <= bus_data;
                        resp.valid     <= 1'b1;
                        bus_drv.iack_n <= 1'b1;
                        bus_drv.addr   <= LVL_NONE;
                        state          <= ST_REL;
                    end else if (cnt == CNT_LAST) begin
                        resp.berr      <= 1'b1;
                        bus_drv.iack_n <= 1'b1;
                        bus_drv.addr   <= LVL_NONE;
                        state          <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_REL: begin
                    if (dtack_n_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_irq_handler.sv
module bus_irq_handler
    import irqh_pkg::*;
#(
    parameter int TMO_CYC = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [6:0]   bus_irq_n,
    input  logic [6:0]   lvl_en,
    input  logic         loc_abort,
    input  logic         loc_acfail,
    input  logic         loc_busclr,
    input  logic         loc_serial,
    input  logic [7:0]   serial_vec,
    input  logic         ack_req,
    input  logic [2:0]   ack_lvl,
    input  logic         bus_dtack_n,
    input  logic [7:0]   bus_data,
    output logic [2:0]   cpu_ipl,
    output logic         bus_iack_n,
    output logic [2:0]   bus_addr,
    output logic [7:0]   cpu_vec,
    output logic         cpu_vec_valid,
    output logic         cpu_autovec,
    output logic         cpu_berr
);
    logic [NUM_LVL-1:0] irq_n_s;
    logic [3:0]         loc_s;
    logic               dtack_n_s;
    logic               serial_pend;
    bus_drv_t           bus_drv;
    cpu_resp_t          resp;

    irqh_sync #(.W(NUM_LVL), .RST_VAL({NUM_LVL{1'b1}})) u_sync_irq (
        .clk(clk), .rst(rst), .d(bus_irq_n), .q(irq_n_s)
    );

    irqh_sync #(.W(4), .RST_VAL(4'b0000)) u_sync_loc (
        .clk(clk), .rst(rst),
        .d({loc_serial, loc_busclr, loc_acfail, loc_abort}),
        .q(loc_s)
    );

    irqh_sync #(.W(1), .RST_VAL(1'b1)) u_sync_dtack (
        .clk(clk), .rst(rst), .d(bus_dtack_n), .q(dtack_n_s)
    );

    irqh_prio u_prio (
        .irq_n_s    (irq_n_s),
        .lvl_en     (lvl_en),
        .loc_top_s  (loc_s[2:0]),
        .serial_s   (loc_s[3]),
        .ipl        (cpu_ipl),
        .serial_pend(serial_pend)
    );

    irqh_ack_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ack_req    (ack_req),
        .ack_lvl    (ack_lvl),
        .serial_pend(serial_pend),
        .serial_vec (serial_vec),
        .dtack_n_s  (dtack_n_s),
        .bus_data   (bus_data),
        .bus_drv    (bus_drv),
        .resp       (resp)
    );

    assign bus_iack_n    = bus_drv.iack_n;
    assign bus_addr      = bus_drv.addr;
    assign cpu_vec       = resp.vec;
    assign cpu_vec_valid = resp.valid;
    assign cpu_autovec   = resp.autovec;
    assign cpu_berr      = resp.berr;
endmodule

// File: rtl/bus_irq_handler_chk.sv
module bus_irq_handler_chk #(
    parameter int TMO_CYC = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_iack_n,
    input logic [2:0] bus_addr,
    input logic       cpu_vec_valid,
    input logic       cpu_autovec,
    input logic       cpu_berr
);
    localparam int LW = $clog2(TMO_CYC + 2);
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)             low_cnt <= '0;
        else if (!bus_iack_n) low_cnt <= low_cnt + 1'b1;
        else                 low_cnt <= '0;
    end

    // R5
    iack_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_iack_n && $past(!bus_iack_n)) |-> $stable(bus_addr));

    // R5
    iack_level_range_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_iack_n) |-> (bus_addr != 3'd0 && bus_addr != 3'd7));

    // R7
    autovec_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_autovec |-> bus_iack_n);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_vec_valid, cpu_autovec, cpu_berr}));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_vec_valid |=> !cpu_vec_valid);

    // R9
    iack_window_chk: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LW'(TMO_CYC));

    // R9
    berr_releases_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_berr |-> bus_iack_n);
endmodule

bind bus_irq_handler bus_irq_handler_chk #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_iack_n   (bus_iack_n),
    .bus_addr     (bus_addr),
    .cpu_vec_valid(cpu_vec_valid),
    .cpu_autovec  (cpu_autovec),
    .cpu_berr     (cpu_berr)
);

// File: tb/bus_irq_handler_tb.sv
module bus_irq_handler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] bus_irq_n = 7'h7F;
    logic [6:0] lvl_en = 7'h00;
    logic       loc_abort = 0, loc_acfail = 0, loc_busclr = 0, loc_serial = 0;
    logic [7:0] serial_vec = 8'h3C;
    logic       ack_req = 0;
    logic [2:0] ack_lvl = 3'd0;
    logic       bus_dtack_n = 1'b1;
    logic [7:0] bus_data = 8'h00;
    logic [2:0] cpu_ipl;
    logic       bus_iack_n;
    logic [2:0] bus_addr;
    logic [7:0] cpu_vec;
    logic       cpu_vec_valid, cpu_autovec, cpu_berr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bus_irq_handler #(.TMO_CYC(TMO)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ack(input logic [2:0] lvl);
        ack_lvl = lvl;
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic t_reset();
        check(cpu_ipl == 3'd0, "R1 ipl", cpu_ipl, 0);
        check(bus_iack_n == 1'b1, "R1 iack", bus_iack_n, 1);
        check(bus_addr == 3'd0, "R1 addr", bus_addr, 0);
        check({cpu_vec_valid, cpu_autovec, cpu_berr} == 3'b000, "R1 strobes",
              {cpu_vec_valid, cpu_autovec, cpu_berr}, 0);
    endtask

    task automatic t_mask();
        lvl_en = 7'h00;
        bus_irq_n[4] = 1'b0;
        cyc(3);
        check(cpu_ipl == 3'd0, "R2 masked level5", cpu_ipl, 0);
        lvl_en[4] = 1'b1;
        #1;
        check(cpu_ipl == 3'd5, "R3 enable same cycle", cpu_ipl, 5);
        cyc(1);
    endtask

    task automatic t_prio();
        lvl_en = 7'h7F;
        bus_irq_n[1] = 1'b0;
        bus_irq_n[5] = 1'b0;
        cyc(1);
        check(cpu_ipl == 3'd5, "R3 one edge no change", cpu_ipl, 5);
        cyc(1);
        check(cpu_ipl == 3'd6, "R3 highest after two edges", cpu_ipl, 6);
        bus_irq_n[5] = 1'b1;
        cyc(2);
        check(cpu_ipl == 3'd5, "R3 drop to level5", cpu_ipl, 5);
        bus_irq_n = 7'h7F;
        cyc(2);
        check(cpu_ipl == 3'd0, "R3 none pending", cpu_ipl, 0);
    endtask

    task automatic t_local();
        lvl_en = 7'h00;
        loc_abort = 1'b1;
        cyc(2);
        check(cpu_ipl == 3'd7, "R4 abort level7", cpu_ipl, 7);
        loc_abort = 1'b0; loc_acfail = 1'b1;
        cyc(2);
        check(cpu_ipl == 3'd7, "R4 acfail level7", cpu_ipl, 7);
        loc_acfail = 1'b0; loc_busclr = 1'b1;
        cyc(2);
        check(cpu_ipl == 3'd7, "R4 busclr level7", cpu_ipl, 7);
        loc_busclr = 1'b0; loc_serial = 1'b1;
        cyc(2);
        check(cpu_ipl == 3'd3, "R4 serial level3", cpu_ipl, 3);
        loc_serial = 1'b0;
        cyc(2);
        check(cpu_ipl == 3'd0, "R4 all released", cpu_ipl, 0);
        lvl_en = 7'h7F;
    endtask

    task automatic bus_cycle(input logic [2:0] lvl, input logic [7:0] data, input string req);
        pulse_ack(lvl);
        check(bus_iack_n == 1'b0, {req, " iack low"}, bus_iack_n, 0);
        check(bus_addr == lvl, {req, " addr"}, bus_addr, lvl);
        cyc(4);
        check(bus_iack_n == 1'b0 && bus_addr == lvl, {req, " held"}, bus_addr, lvl);
        bus_data = data;
        bus_dtack_n = 1'b0;
        cyc(2);
        check(cpu_vec_valid == 1'b0, "R6 not before third edge", cpu_vec_valid, 0);
        cyc(1);
        check(cpu_vec_valid == 1'b1, "R6 valid", cpu_vec_valid, 1);
        check(cpu_vec == data, "R6 vector", cpu_vec, data);
        check(bus_iack_n == 1'b1, "R6 iack released", bus_iack_n, 1);
        cyc(1);
        check(cpu_vec_valid == 1'b0, "R6 one-cycle strobe", cpu_vec_valid, 0);
    endtask

    task automatic release_dtack();
        bus_dtack_n = 1'b1;
        cyc(4);
    endtask

    task automatic t_bus_ack();
        bus_cycle(3'd4, 8'hA5, "R5 level4");
    endtask

    task automatic t_busy();
        // dtack still low from t_bus_ack
        pulse_ack(3'd2);
        cyc(1);
        check(bus_iack_n == 1'b1, "R11 ack ignored while dtack held", bus_iack_n, 1);
        release_dtack();
        check(bus_iack_n == 1'b1, "R11 no late start", bus_iack_n, 1);
    endtask

    task automatic t_auto();
        pulse_ack(3'd7);
        check(cpu_autovec == 1'b1, "R7 autovec", cpu_autovec, 1);
        check(bus_iack_n == 1'b1, "R7 no bus cycle", bus_iack_n, 1);
        cyc(1);
        check(cpu_autovec == 1'b0, "R7 one cycle", cpu_autovec, 0);
    endtask

    task automatic t_serial();
        loc_serial = 1'b1;
        cyc(2);
        pulse_ack(3'd3);
        check(cpu_vec_valid == 1'b1 && cpu_vec == 8'h3C, "R8 local vector", cpu_vec, 8'h3C);
        check(bus_iack_n == 1'b1, "R8 no bus cycle", bus_iack_n, 1);
        loc_serial = 1'b0;
        cyc(3);
        bus_cycle(3'd3, 8'h81, "R5 level3 bus");
        release_dtack();
    endtask

    task automatic t_timeout();
        int seen = -1;
        ack_lvl = 3'd2;
        ack_req = 1'b1;
        for (int i = 1; i <= TMO + 10; i++) begin
            @(negedge clk);
            ack_req = 1'b0;
            if (cpu_berr && seen < 0) seen = i;
        end
        check(seen == TMO + 1, "R9 berr timing", seen, TMO + 1);
        check(bus_iack_n == 1'b1, "R9 iack released", bus_iack_n, 1);
        check(cpu_vec_valid == 1'b0, "R9 no vector", cpu_vec_valid, 0);
    endtask

    task automatic t_zero();
        pulse_ack(3'd0);
        check(cpu_berr == 1'b1, "R10 berr on level0", cpu_berr, 1);
        check(bus_iack_n == 1'b1, "R10 no bus cycle", bus_iack_n, 1);
        cyc(1);
        check(cpu_berr == 1'b0, "R10 one cycle", cpu_berr, 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_mask();
        t_prio();
        t_local();
        t_bus_ack();
        t_busy();
        t_auto();
        t_serial();
        t_timeout();
        t_zero();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule